// File: doc/BRIEF.md
# Multi-Format Page Table Walker

The walker turns one virtual address into a physical address by reading translation tables from memory, one entry at a time. It understands four layouts: no translation at all, a 32-bit layout of two levels with 4-byte entries, a three-level layout with 8-byte entries whose first level holds four pointers, and a 64-bit layout of four or five levels. The layout is chosen by the paging-enable, wide-entry, large-page-enable, five-level and 64-bit-mode inputs, together with the table root and an address mask that can force bit 20 of every fetch low.

A request is a single-cycle `reqValid` pulse while `busy` is low. The walker then issues at most one memory read at a time on a plain request/response port and ends with a one-cycle `done`. In that cycle `physAddr` holds the translation, or `fault` is high. Access rights, accessed/dirty updates and caching of translations are left to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: With `cfgPaging` low, the walk issues no memory read and ends with `fault` low and `physAddr` = `reqVaddr` AND `cfgA20Mask`.
- R2: In the 32-bit layout (`cfgPaging`=1, `cfgPae`=0, `cfgLong`=0), the first read is at (`cfgRoot` with bits 11:0 cleared) + 4 × va[31:22]. The second read is at (bits 31:12 of the first entry) + 4 × va[21:12]. Both reads have `memReqWide`=0. A 4 KB leaf gives frame bits 31:12 from the entry.
- R3: In the 32-bit layout, a first-level entry with bit 7 set while `cfgPse` is 1 is a 4 MB leaf: physical bits 31:22 come from entry bits 31:22, physical bits 39:32 from entry bits 20:13, and the low 22 bits from the virtual address. With `cfgPse` 0, bit 7 has no effect and the entry points to a second-level table.
- R4: In the three-level layout (`cfgPae`=1, `cfgLong`=0), the first read is at (`cfgRoot` with bits 4:0 cleared) + 8 × va[31:30]. The next reads use 9-bit indices va[29:21] and then va[20:12], times 8. Every read has `memReqWide`=1.
- R5: In 64-bit mode (`cfgLong`=1), the level-n read (n = 5 down to 1) is at the base + 8 × va[12+9(n-1)+8 : 12+9(n-1)]. The walk starts at level 5 when `cfgLa57` is 1 and at level 4 otherwise, so a 4 KB walk issues 5 or 4 reads.
- R6: With 8-byte entries, bit 7 set in a level-2 entry makes a 2 MB leaf. In 64-bit mode, bit 7 set in a level-3 entry makes a 1 GB leaf. The walk ends after that read.
- R7: In 64-bit mode, if va[63:47] (va[63:56] with `cfgLa57`) are not all equal, the walk ends with `fault` and no memory read.
- R8: A fetched entry with bit 0 clear ends the walk with `fault` high; no further read is issued.
- R9: Every table read address is ANDed with `cfgA20Mask`. The final address is also ANDed with it in the 32-bit layout, but not with 8-byte entries.
- R10: The result is the leaf's frame field (bits 51:12 for 8-byte entries, so bits 63:52 are dropped) with the bits below the page size cleared, ORed with those low bits of the virtual address.
- R11: `busy` rises the cycle after an accepted `reqValid`. `done` is a single-cycle pulse while `busy` is high, and `busy` falls after it. A new read is issued only after the previous read has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a walk (taken while busy is low) |
| reqVaddr | input | VA_W | Virtual address to translate |
| cfgPaging | input | 1 | Translation enabled |
| cfgPae | input | 1 | 8-byte entry layout |
| cfgPse | input | 1 | 4 MB pages allowed in 32-bit layout |
| cfgLa57 | input | 1 | Five-level 64-bit walk |
| cfgLong | input | 1 | 64-bit mode |
| cfgRoot | input | PA_W | Table root address |
| cfgA20Mask | input | PA_W | Mask ANDed into table addresses |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed (valid with done) |
| physAddr | output | PA_W | Translated address (valid with done) |
| memReqValid | output | 1 | Memory read request, one cycle |
| memReqAddr | output | PA_W | Read address |
| memReqWide | output | 1 | 1: 64-bit read, 0: 32-bit read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data (low half for 32-bit reads) |

## Verification
The hardest case to reach is a table base that has address bit 20 set in the middle of a walk, where only the mask keeps the fetch off the aliased location. The bench builds a full 64-bit table chain under a root with bit 20 set and places the entries only at the masked addresses. A fetch that skipped the mask would then read zeros and fault. The five-level case is reached with one address that is out of range for four levels but valid for five, so the same stimulus checks both the range test and the extra level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENT_W   = 64;
  localparam int PRES_B  = 0;
  localparam int LEAF_B  = 7;

  typedef enum logic [1:0] {
    FMT_FLAT,
    FMT_TWO,
    FMT_PAE,
    FMT_LONG
  } ptwFmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } ptwState_e;

  typedef struct packed {
    logic load;
    logic start;
    logic descend;
    logic setLeaf;
    logic setFault;
    logic setFlat;
  } ptwStrobe_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isFlat,
  input  logic       nonCanon,
  input  logic       rspValid,
  input  logic       rspPresent,
  input  logic       rspLeaf,
  output ptwStrobe_t strobe,
  output logic       busy,
  output logic       memReqValid,
  output logic       done
);

  ptwState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    memReqValid = 1'b0;
    done        = 1'b0;
    busy        = (stateQ != ST_IDLE);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = ST_START;
        end
      end
      ST_START: begin
        if (isFlat) begin
          strobe.setFlat = 1'b1;
          stateD         = ST_RESP;
        end else if (nonCanon) begin
          strobe.setFault = 1'b1;
          stateD          = ST_RESP;
        end else begin
          strobe.start = 1'b1;
          stateD       = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memReqValid = 1'b1;
        stateD      = ST_WAIT;
      end
      ST_WAIT: begin
        if (rspValid) begin
          if (!rspPresent) begin
            strobe.setFault = 1'b1;
            stateD          = ST_RESP;
          end else if (rspLeaf) begin
            strobe.setLeaf = 1'b1;
            stateD         = ST_RESP;
          end else begin
            strobe.descend = 1'b1;
            stateD         = ST_ISSUE;
          end
        end
      end
      ST_RESP: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 52
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptwStrobe_t       strobe,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             cfgPaging,
  input  logic             cfgPae,
  input  logic             cfgPse,
  input  logic             cfgLa57,
  input  logic             cfgLong,
  input  logic [PA_W-1:0]  cfgRoot,
  input  logic [PA_W-1:0]  cfgA20Mask,
  input  logic [ENT_W-1:0] memRspData,
  output logic             isFlat,
  output logic             nonCanon,
  output logic             rspPresent,
  output logic             rspLeaf,
  output logic [PA_W-1:0]  memReqAddr,
  output logic             memReqWide,
  output logic [PA_W-1:0]  physAddr,
  output logic             fault
);

  localparam logic [PA_W-1:0] PAGE_ALIGN = ~PA_W'(12'hfff);
  localparam logic [PA_W-1:0] PTR_ALIGN  = ~PA_W'(5'h1f);

  ptwFmt_e          fmtQ;
  logic [VA_W-1:0]  vaQ;
  logic             pseQ, la57Q;
  logic [PA_W-1:0]  rootQ, a20Q, baseQ, physQ;
  logic [2:0]       levelQ;
  logic             faultQ;

  // format decode of the live configuration, captured at load
  ptwFmt_e fmtIn;
  always_comb begin
    if (!cfgPaging)   fmtIn = FMT_FLAT;
    else if (cfgLong) fmtIn = FMT_LONG;
    else if (cfgPae)  fmtIn = FMT_PAE;
    else              fmtIn = FMT_TWO;
  end

  // range check of the upper virtual bits
  logic [VA_W-1:47] upper4;
  logic [VA_W-1:56] upper5;
  logic             sameUpper;
  assign upper4    = vaQ[VA_W-1:47];
  assign upper5    = vaQ[VA_W-1:56];
  assign sameUpper = la57Q ? ((&upper5) | ~(|upper5)) : ((&upper4) | ~(|upper4));
  assign nonCanon  = (fmtQ == FMT_LONG) && !sameUpper;
  assign isFlat    = (fmtQ == FMT_FLAT);

  // per-level index position for 9-bit indices
  logic [5:0] idxShift;
  always_comb begin
    unique case (levelQ)
      3'd1:    idxShift = 6'd12;
      3'd2:    idxShift = 6'd21;
      3'd3:    idxShift = 6'd30;
      3'd4:    idxShift = 6'd39;
      3'd5:    idxShift = 6'd48;
      default: idxShift = 6'd12;
    endcase
  end

  logic [VA_W-1:0] vaShifted;
  logic [8:0]      idx9;
  assign vaShifted = vaQ >> idxShift;
  assign idx9      = vaShifted[8:0];

  // entry offset inside the current table
  logic [PA_W-1:0] entOff;
  always_comb begin
    unique case (fmtQ)
      FMT_TWO:
        entOff = (levelQ == 3'd2) ? PA_W'({vaQ[31:22], 2'b00})
                                  : PA_W'({vaQ[21:12], 2'b00});
      FMT_PAE:
        entOff = (levelQ == 3'd3) ? PA_W'({vaQ[31:30], 3'b000})
                                  : PA_W'({idx9, 3'b000});
      default:
        entOff = PA_W'({idx9, 3'b000});
    endcase
  end

  assign memReqAddr = (baseQ + entOff) & a20Q;
  assign memReqWide = (fmtQ != FMT_TWO);

  // classification of the returned entry
  logic psBit;
  assign psBit      = memRspData[LEAF_B];
  assign rspPresent = memRspData[PRES_B];
  always_comb begin
    unique case (fmtQ)
      FMT_TWO:  rspLeaf = (levelQ == 3'd1) || ((levelQ == 3'd2) && psBit && pseQ);
      FMT_PAE:  rspLeaf = (levelQ == 3'd1) || ((levelQ == 3'd2) && psBit);
      FMT_LONG: rspLeaf = (levelQ == 3'd1) ||
                          (((levelQ == 3'd2) || (levelQ == 3'd3)) && psBit);
      default:  rspLeaf = 1'b1;
    endcase
  end

  // page size of the leaf, as a count of offset bits
  logic [4:0] pageBits;
  always_comb begin
    if (fmtQ == FMT_TWO)
      pageBits = (levelQ == 3'd2) ? 5'd22 : 5'd12;
    else begin
      unique case (levelQ)
        3'd2:    pageBits = 5'd21;
        3'd3:    pageBits = 5'd30;
        default: pageBits = 5'd12;
      endcase
    end
  end

  // frame field of the returned entry
  logic [PA_W-1:0] frameNarrow, frameWide, frameRaw, offMask, nextBase, leafAddr;
  always_comb begin
    frameNarrow       = '0;
    frameNarrow[31:0] = memRspData[31:0];
    if (levelQ == 3'd2)
      frameNarrow[39:32] = memRspData[20:13];
    frameNarrow = frameNarrow & a20Q;
  end
  assign frameWide = memRspData[PA_W-1:0];
  assign frameRaw  = (fmtQ == FMT_TWO) ? frameNarrow : frameWide;
  assign offMask   = (PA_W'(1) << pageBits) - PA_W'(1);
  assign leafAddr  = (frameRaw & ~offMask) | (vaQ[PA_W-1:0] & offMask);
  assign nextBase  = (fmtQ == FMT_TWO) ? PA_W'({memRspData[31:12], 12'h000})
                                       : (frameWide & PAGE_ALIGN);

  logic [ENT_W-1:PA_W] unusedEntHi;
  assign unusedEntHi = memRspData[ENT_W-1:PA_W];

  // first level and its base
  logic [2:0]      firstLevel;
  logic [PA_W-1:0] firstBase;
  always_comb begin
    unique case (fmtQ)
      FMT_LONG: firstLevel = la57Q ? 3'd5 : 3'd4;
      FMT_PAE:  firstLevel = 3'd3;
      default:  firstLevel = 3'd2;
    endcase
    firstBase = (fmtQ == FMT_PAE) ? (rootQ & PTR_ALIGN) : (rootQ & PAGE_ALIGN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtQ   <= FMT_FLAT;
      vaQ    <= '0;
      pseQ   <= 1'b0;
      la57Q  <= 1'b0;
      rootQ  <= '0;
      a20Q   <= '0;
      baseQ  <= '0;
      levelQ <= '0;
      physQ  <= '0;
      faultQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        fmtQ   <= fmtIn;
        vaQ    <= reqVaddr;
        pseQ   <= cfgPse;
        la57Q  <= cfgLa57;
        rootQ  <= cfgRoot;
        a20Q   <= cfgA20Mask;
        faultQ <= 1'b0;
      end
      if (strobe.start) begin
        levelQ <= firstLevel;
        baseQ  <= firstBase;
      end
      if (strobe.descend) begin
        levelQ <= levelQ - 3'd1;
        baseQ  <= nextBase;
      end
      if (strobe.setLeaf) begin
        physQ  <= leafAddr;
        faultQ <= 1'b0;
      end
      if (strobe.setFlat) begin
        physQ  <= vaQ[PA_W-1:0] & a20Q;
        faultQ <= 1'b0;
      end
      if (strobe.setFault) begin
        physQ  <= '0;
        faultQ <= 1'b1;
      end
    end
  end

  assign physAddr = physQ;
  assign fault    = faultQ;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 52
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             cfgPaging,
  input  logic             cfgPae,
  input  logic             cfgPse,
  input  logic             cfgLa57,
  input  logic             cfgLong,
  input  logic [PA_W-1:0]  cfgRoot,
  input  logic [PA_W-1:0]  cfgA20Mask,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  physAddr,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  output logic             memReqWide,
  input  logic             memRspValid,
  input  logic [ENT_W-1:0] memRspData
);

  ptwStrobe_t strobe;
  logic       isFlat, nonCanon, rspPresent, rspLeaf;

  ptw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .isFlat     (isFlat),
    .nonCanon   (nonCanon),
    .rspValid   (memRspValid),
    .rspPresent (rspPresent),
    .rspLeaf    (rspLeaf),
    .strobe     (strobe),
    .busy       (busy),
    .memReqValid(memReqValid),
    .done       (done)
  );

  ptw_dpath #(.VA_W(VA_W), .PA_W(PA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .cfgPaging  (cfgPaging),
    .cfgPae     (cfgPae),
    .cfgPse     (cfgPse),
    .cfgLa57    (cfgLa57),
    .cfgLong    (cfgLong),
    .cfgRoot    (cfgRoot),
    .cfgA20Mask (cfgA20Mask),
    .memRspData (memRspData),
    .isFlat     (isFlat),
    .nonCanon   (nonCanon),
    .rspPresent (rspPresent),
    .rspLeaf    (rspLeaf),
    .memReqAddr (memReqAddr),
    .memReqWide (memReqWide),
    .physAddr   (physAddr),
    .fault      (fault)
  );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            busy,
  input logic            done,
  input logic            memReqValid,
  input logic [PA_W-1:0] memReqAddr,
  input logic            memReqWide,
  input logic            cfgPaging,
  input logic            cfgPae,
  input logic            cfgLong,
  input logic [PA_W-1:0] cfgA20Mask
);

  // R11: completion only inside a walk, and only for one cycle
  a_r11_done_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R11: a walk starts only from an accepted request
  a_r11_start_from_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  // R11: one read at a time, issued only during a walk
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  a_r11_read_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);
  // R1: no table reads without translation
  a_r1_flat_no_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> cfgPaging);
  // R2: 32-bit layout reads narrow entries
  a_r2_narrow_read: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !cfgPae && !cfgLong) |-> !memReqWide);
  // R4: 8-byte layouts read wide entries
  a_r4_wide_read: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && (cfgPae || cfgLong)) |-> memReqWide);
  // R9: every fetch address is masked
  a_r9_masked_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ((memReqAddr & ~cfgA20Mask) == '0));

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

  localparam int VA_W = 64;
  localparam int PA_W = 52;
  localparam logic [63:0] FRAME64 = 64'h000F_FFFF_FFFF_F000;
  localparam logic [63:0] ALL52   = 64'h000F_FFFF_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic            cfgPaging = 1'b0, cfgPae = 1'b0, cfgPse = 1'b0;
  logic            cfgLa57 = 1'b0, cfgLong = 1'b0;
  logic [PA_W-1:0] cfgRoot = '0;
  logic [PA_W-1:0] cfgA20Mask = '1;
  logic            busy, done, fault, memReqValid, memReqWide;
  logic [PA_W-1:0] physAddr, memReqAddr;
  logic            memRspValid = 1'b0;
  logic [63:0]     memRspData = '0;

  ptw_walker #(.VA_W(VA_W), .PA_W(PA_W)) dut_i (.*);

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  // sparse memory of 8-byte words
  logic [63:0] mem [logic [63:0]];
  int          reqCnt;
  logic [63:0] reqFirst, reqSecond;
  logic        sawNarrow, sawWide;
  int          pend = 0;
  logic [63:0] pendAddr = '0;

  function automatic logic [63:0] rdWord(input logic [63:0] a);
    logic [63:0] k;
    k = a >> 3;
    return mem.exists(k) ? mem[k] : 64'h0;
  endfunction

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (pend == 1) begin
      memRspValid = 1'b1;
      memRspData  = rdWord(pendAddr);
      if (pendAddr[2] && !memReqWideQ) memRspData = {32'h0, memRspData[63:32]};
      else if (!memReqWideQ)           memRspData = {32'h0, memRspData[31:0]};
    end
    if (pend > 0) pend--;
    if (memReqValid) begin
      if (reqCnt == 0) reqFirst = 64'(memReqAddr);
      if (reqCnt == 1) reqSecond = 64'(memReqAddr);
      reqCnt++;
      if (memReqWide) sawWide = 1'b1; else sawNarrow = 1'b1;
      pendAddr    = 64'(memReqAddr);
      memReqWideQ = memReqWide;
      pend        = 2;
    end
  end
  logic memReqWideQ = 1'b0;

  task automatic wr64(input logic [63:0] a, input logic [63:0] d);
    mem[a >> 3] = d;
  endtask

  task automatic wr32(input logic [63:0] a, input logic [31:0] d);
    logic [63:0] w;
    w = rdWord(a);
    if (a[2]) w[63:32] = d; else w[31:0] = d;
    mem[a >> 3] = w;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] gotPhys;
  logic        gotFault;

  task automatic doWalk(input logic [63:0] va);
    int n;
    reqCnt    = 0;
    sawNarrow = 1'b0;
    sawWide   = 1'b0;
    reqFirst  = '0;
    reqSecond = '0;
    reqVaddr  = va;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", 64'(busy), 64'd1);
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R11 done reached", 64'(done), 64'd1);
    gotPhys  = 64'(physAddr);
    gotFault = fault;
    @(negedge clk);
    check(done == 1'b0, "R11 done single cycle", 64'(done), 64'd0);
    check(busy == 1'b0, "R11 busy released", 64'(busy), 64'd0);
  endtask

  task automatic setMode(input bit pg, input bit pae, input bit pse, input bit lng,
                         input bit la57);
    cfgPaging = pg; cfgPae = pae; cfgPse = pse; cfgLong = lng; cfgLa57 = la57;
  endtask

  // 64-bit layout table chain
  function automatic logic [63:0] tblBase(input int lvl);
    return 64'h20_0000 * 64'(lvl);
  endfunction

  function automatic logic [63:0] idxOf(input logic [63:0] va, input int lvl);
    return (va >> (12 + 9 * (lvl - 1))) & 64'h1ff;
  endfunction

  task automatic buildLong(input logic [63:0] va, input bit la57, input int leafLvl,
                           input logic [63:0] leafEnt, input int missLvl);
    int top;
    logic [63:0] base, a;
    top = la57 ? 5 : 4;
    for (int lvl = top; lvl >= leafLvl; lvl--) begin
      base = (lvl == top) ? (64'(cfgRoot) & ~64'hfff) : tblBase(lvl);
      a    = (base + idxOf(va, lvl) * 8) & 64'(cfgA20Mask);
      if (lvl == missLvl) begin
        wr64(a, 64'h0);
        break;
      end
      wr64(a, (lvl == leafLvl) ? leafEnt : (tblBase(lvl - 1) | 64'h3));
    end
  endtask

  function automatic logic [63:0] leafExp(input logic [63:0] ent, input logic [63:0] va,
                                          input int bits);
    logic [63:0] m;
    m = (64'h1 << bits) - 1;
    return (ent & FRAME64 & ~m) | (va & m & ALL52);
  endfunction

  // ---------------- scenarios ----------------
  task automatic testReset();
    check(busy == 1'b0, "R11 reset busy", 64'(busy), 64'd0);
    check(done == 1'b0, "R11 reset done", 64'(done), 64'd0);
    check(memReqValid == 1'b0, "R11 reset memReqValid", 64'(memReqValid), 64'd0);
  endtask

  task automatic testFlat();
    setMode(0, 0, 0, 0, 0);
    cfgA20Mask = ~PA_W'(1 << 20);
    doWalk(64'h0000_0000_1234_5678);
    check(reqCnt == 0, "R1 flat no read", 64'(reqCnt), 64'd0);
    check(gotFault == 1'b0, "R1 flat fault", 64'(gotFault), 64'd0);
    check(gotPhys == 64'h1224_5678, "R1 R9 flat masked", gotPhys, 64'h1224_5678);
    cfgA20Mask = '1;
  endtask

  task automatic testTwo4k();
    mem.delete();
    setMode(1, 0, 1, 0, 0);
    cfgRoot = PA_W'(64'h1abc);
    wr32(64'h1004, 32'h0000_2003);
    wr32(64'h200c, 32'h0055_5001);
    doWalk(64'h0040_3123);
    check(reqFirst == 64'h1004, "R2 first addr", reqFirst, 64'h1004);
    check(reqSecond == 64'h200c, "R2 second addr", reqSecond, 64'h200c);
    check(!sawWide && sawNarrow, "R2 narrow reads", 64'(sawWide), 64'd0);
    check(gotPhys == 64'h55_5123 && !gotFault, "R2 R10 result", gotPhys, 64'h55_5123);
  endtask

  task automatic testTwo4m();
    mem.delete();
    setMode(1, 0, 1, 0, 0);
    cfgRoot = PA_W'(64'h1abc);
    wr32(64'h1008, 32'hC000_A081);
    doWalk(64'h0080_1234);
    check(reqCnt == 1, "R3 large page one read", 64'(reqCnt), 64'd1);
    check(gotPhys == 64'h5_C000_1234 && !gotFault, "R3 4MB result", gotPhys,
          64'h5_C000_1234);
  endtask

  task automatic testTwoNoPse();
    mem.delete();
    setMode(1, 0, 0, 0, 0);
    cfgRoot = PA_W'(64'h1abc);
    wr32(64'h1008, 32'hC000_A081);
    wr32(64'hC000_A004, 32'h0077_7001);
    doWalk(64'h0080_1234);
    check(reqCnt == 2, "R3 size bit ignored reads", 64'(reqCnt), 64'd2);
    check(reqSecond == 64'hC000_A004, "R3 table addr", reqSecond, 64'hC000_A004);
    check(gotPhys == 64'h77_7234, "R3 size bit ignored result", gotPhys, 64'h77_7234);
  endtask

  task automatic testTwoMiss();
    mem.delete();
    setMode(1, 0, 1, 0, 0);
    cfgRoot = PA_W'(64'h1000);
    wr32(64'h1004, 32'h0000_2002);
    doWalk(64'h0040_3123);
    check(gotFault == 1'b1, "R8 narrow not present", 64'(gotFault), 64'd1);
    check(reqCnt == 1, "R8 narrow stops", 64'(reqCnt), 64'd1);
  endtask

  task automatic testPae();
    mem.delete();
    setMode(1, 1, 0, 0, 0);
    cfgRoot = PA_W'(64'h3027);
    wr64(64'h3038, 64'h4001);
    wr64(64'h4018, 64'h5001);
    wr64(64'h5010, 64'h0000_000A_BCDE_F001);
    doWalk(64'hC060_2345);
    check(reqFirst == 64'h3038, "R4 pointer addr", reqFirst, 64'h3038);
    check(reqSecond == 64'h4018, "R4 second addr", reqSecond, 64'h4018);
    check(reqCnt == 3 && sawWide && !sawNarrow, "R4 three wide reads", 64'(reqCnt), 64'd3);
    check(gotPhys == 64'hA_BCDE_F345, "R4 R10 result", gotPhys, 64'hA_BCDE_F345);
    // 2 MB leaf with stray low frame bits
    wr64(64'h4018, 64'h1_2340_1081);
    doWalk(64'hC060_2345);
    check(reqCnt == 2, "R6 2MB reads", 64'(reqCnt), 64'd2);
    check(gotPhys == 64'h1_2340_2345, "R6 2MB result", gotPhys, 64'h1_2340_2345);
  endtask

  task automatic testLong4k();
    logic [63:0] va, ent;
    mem.delete();
    setMode(1, 1, 0, 1, 0);
    cfgRoot = PA_W'(64'h0A0_0000);
    va  = (64'h0FF << 39) | (64'h1A0 << 30) | (64'h055 << 21) | (64'h1FF << 12) | 64'hABC;
    ent = 64'h800F_EDCB_A987_6003;
    buildLong(va, 0, 1, ent, 0);
    doWalk(va);
    check(reqCnt == 4, "R5 four levels", 64'(reqCnt), 64'd4);
    check(reqFirst == 64'hA0_0000 + 64'h0FF * 8, "R5 first index", reqFirst,
          64'hA0_0000 + 64'h0FF * 8);
    check(gotPhys == leafExp(ent, va, 12) && !gotFault, "R10 frame field", gotPhys,
          leafExp(ent, va, 12));
  endtask

  task automatic testLong1g();
    logic [63:0] va, ent;
    mem.delete();
    setMode(1, 1, 0, 1, 0);
    cfgRoot = PA_W'(64'h0A0_0000);
    va  = 64'hFFFF_8000_0000_0000 | (64'h033 << 30) | 64'h1234_5678;
    ent = 64'h0000_00C0_1234_5083;
    buildLong(va, 0, 3, ent, 0);
    doWalk(va);
    check(reqCnt == 2, "R6 1GB reads", 64'(reqCnt), 64'd2);
    check(gotPhys == leafExp(ent, va, 30) && !gotFault, "R6 R7 1GB upper half", gotPhys,
          leafExp(ent, va, 30));
  endtask

  task automatic testLa57();
    logic [63:0] va, ent;
    mem.delete();
    setMode(1, 1, 0, 1, 0);
    cfgRoot = PA_W'(64'h0A0_0000);
    va = 64'h0012_3456_789A_BCDE;
    doWalk(va);
    check(gotFault == 1'b1 && reqCnt == 0, "R7 out of range for four levels",
          64'(gotFault), 64'd1);
    cfgLa57 = 1'b1;
    ent = 64'h0000_0001_2345_6003;
    buildLong(va, 1, 1, ent, 0);
    doWalk(va);
    check(reqCnt == 5, "R5 five levels", 64'(reqCnt), 64'd5);
    check(reqFirst == 64'hA0_0000 + idxOf(va, 5) * 8, "R5 fifth index", reqFirst,
          64'hA0_0000 + idxOf(va, 5) * 8);
    check(gotPhys == leafExp(ent, va, 12) && !gotFault, "R5 five level result", gotPhys,
          leafExp(ent, va, 12));
    doWalk(64'h0100_0000_0000_0000);
    check(gotFault == 1'b1 && reqCnt == 0, "R7 out of range for five levels",
          64'(gotFault), 64'd1);
    cfgLa57 = 1'b0;
  endtask

  task automatic testLongMiss();
    logic [63:0] va;
    mem.delete();
    setMode(1, 1, 0, 1, 0);
    cfgRoot = PA_W'(64'h0A0_0000);
    va = (64'h011 << 39) | (64'h022 << 30) | (64'h033 << 21) | 64'h777;
    buildLong(va, 0, 1, 64'h1003, 2);
    doWalk(va);
    check(gotFault == 1'b1, "R8 wide not present", 64'(gotFault), 64'd1);
    check(reqCnt == 3, "R8 walk ends at miss", 64'(reqCnt), 64'd3);
  endtask

  task automatic testA20Long();
    logic [63:0] va, ent, expFirst;
    mem.delete();
    setMode(1, 1, 0, 1, 0);
    cfgA20Mask = ~PA_W'(1 << 20);
    cfgRoot    = PA_W'(64'hA10_0000);
    va  = (64'h005 << 39) | (64'h006 << 30) | (64'h007 << 21) | (64'h008 << 12) | 64'h321;
    ent = 64'h0000_0000_0FF0_0003;
    buildLong(va, 0, 1, ent, 0);
    expFirst = (64'hA10_0000 + 64'h005 * 8) & ~64'h10_0000;
    doWalk(va);
    check(reqFirst == expFirst, "R9 masked table fetch", reqFirst, expFirst);
    check(gotPhys == 64'hFF0_0321 && !gotFault, "R9 wide result unmasked", gotPhys,
          64'hFF0_0321);
    cfgA20Mask = '1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testFlat();
    testTwo4k();
    testTwo4m();
    testTwoNoPse();
    testTwoMiss();
    testPae();
    testLong4k();
    testLong1g();
    testLa57();
    testLongMiss();
    testA20Long();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule